// File: doc/BRIEF.md
# Single-Bit ECC Syndrome Corrector

This block checks one 512-byte data block that is guarded by a 24-bit row/column parity code. It compares the three check bytes read back from flash with the three bytes computed over the data that just arrived. It then sorts the outcome into one of four cases: clean, correctable data error, error confined to the check bytes, or uncorrectable. For a correctable data error it works out which byte and which bit are wrong. It then repairs the bit in an attached byte-wide page buffer by reading that byte, inverting the bit and writing the byte back.

A host pulses `startStrobe` with both check-byte triples and the blank-ignore enable valid. One or three cycles later the block raises `done` for a single cycle, together with a two-bit status. The error location stays on `errByte` and `errBit` until the next accepted start. Producing the check bytes is left to other logic.

Top module: `ecc_fix_top`

## Requirements
- R1: The syndrome is the bitwise XOR of the stored and computed 24-bit check words (byte k in bits 8k+7..8k). A zero syndrome gives status 2'b00 and causes no buffer access.
- R2: When the stored word is 24'hFFFFFF and `ignoreBlank` is 1, a non-zero syndrome still gives status 2'b00 with no write. With `ignoreBlank` at 0, the same inputs are classified by R3, R5 and R6.
- R3: A syndrome in which every bit pair (2p+1, 2p) holds unequal values is a correctable data error with status 2'b01. Then `errBit` = {s[23], s[21], s[19]} and `errByte` = {s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1]}.
- R4: For a correctable data error the block first reads address `errByte`, with data returned one cycle after `bufRdEn`. In the following cycle it writes the same address with that data XOR (1 << `errBit`). There is exactly one write per such operation.
- R5: A syndrome with exactly one bit set gives status 2'b01 and no buffer write.
- R6: Any other non-zero syndrome gives status 2'b11 and no buffer write.
- R7: `done` is a one-cycle pulse. Take the clock edge that samples the start strobe as edge 1. Without a write, `done` is high after edge 2. With a write, it is high after edge 4. Status holds until the next start.
- R8: Start strobes that arrive while `busy` is high are ignored. The result, the location and the number of writes are those of the accepted start.
- R9: After reset, `done`, `busy`, `bufRdEn` and `bufWrEn` are 0 and status is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startStrobe | input | 1 | Begin a check; sampled only while idle |
| ignoreBlank | input | 1 | Treat an all-ones stored code as clean |
| storedEcc | input | 24 | Check bytes read from flash, byte 0 in the low bits |
| calcEcc | input | 24 | Check bytes computed over the data read |
| bufRdData | input | 8 | Page buffer read data, one cycle after the read |
| bufAddr | output | 9 | Page buffer byte address |
| bufRdEn | output | 1 | Page buffer read request |
| bufWrEn | output | 1 | Page buffer write request |
| bufWrData | output | 8 | Corrected byte to write back |
| busy | output | 1 | An accepted check is in progress |
| done | output | 1 | One-cycle result strobe |
| status | output | 2 | 00 clean, 01 corrected, 11 uncorrectable |
| errByte | output | 9 | Byte index of a data error |
| errBit | output | 3 | Bit index of a data error |

## Verification
Two events can fall in the same cycle: a new start strobe can arrive while the buffer read-modify-write is under way, or during the cycle in which `done` is high. The bench keeps the strobe high with a different check-word pair from the capture cycle through the `done` cycle of a correcting operation. The new inputs would produce a different location if they were taken. The run passes only if status, location, write address and write data all match the first inputs, exactly one write occurs, and `busy` drops one cycle after `done`.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  typedef enum logic [1:0] {
    CLS_OK       = 2'd0,
    CLS_FIX_DATA = 2'd1,
    CLS_FIX_ECC  = 2'd2,
    CLS_BAD      = 2'd3
  } eccClass_e;

  localparam logic [1:0] ST_OK    = 2'b00;
  localparam logic [1:0] ST_FIXED = 2'b01;
  localparam logic [1:0] ST_BAD   = 2'b11;

  typedef struct packed {
    logic capture;
    logic latchResult;
    logic rdEn;
    logic wrEn;
  } ctlStrobe_t;

endpackage

// File: rtl/ecc_fix_datapath.sv
module ecc_fix_datapath
  import ecc_fix_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int ECC_BYTES = 3,
  localparam int SYN_W    = BYTE_W * ECC_BYTES,
  localparam int LOC_W    = SYN_W / 2,
  localparam int BIT_W    = $clog2(BYTE_W),
  localparam int ADDR_W   = LOC_W - BIT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [SYN_W-1:0]  storedEcc,
  input  logic [SYN_W-1:0]  calcEcc,
  input  logic              ignoreBlank,
  input  logic [BYTE_W-1:0] bufRdData,
  output eccClass_e         cls,
  output logic [ADDR_W-1:0] errByte,
  output logic [BIT_W-1:0]  errBit,
  output logic [BYTE_W-1:0] bufWrData,
  output logic [1:0]        status
);

  logic [SYN_W-1:0] syndReg;
  logic             blankReg;
  logic [LOC_W-1:0] pairDiff;
  logic [LOC_W-1:0] locBits;
  logic             allPairs;
  logic             oneHot;
  logic [BYTE_W-1:0] bitMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syndReg  <= '0;
      blankReg <= 1'b0;
    end else if (strobe.capture) begin
      syndReg  <= storedEcc ^ calcEcc;
      blankReg <= ignoreBlank & (&storedEcc);
    end
  end

  // Each pair of syndrome bits: the odd member carries the location bit.
  for (genvar p = 0; p < LOC_W; p++) begin : g_pair
    assign pairDiff[p] = syndReg[2*p] ^ syndReg[2*p+1];
    assign locBits[p]  = syndReg[2*p+1];
  end

  assign allPairs = &pairDiff;
  assign oneHot   = (syndReg != '0) && ((syndReg & (syndReg - SYN_W'(1))) == '0);

  always_comb begin
    if (syndReg == '0)      cls = CLS_OK;
    else if (blankReg)      cls = CLS_OK;
    else if (allPairs)      cls = CLS_FIX_DATA;
    else if (oneHot)        cls = CLS_FIX_ECC;
    else                    cls = CLS_BAD;
  end

  assign errByte   = locBits[ADDR_W-1:0];
  assign errBit    = locBits[LOC_W-1:ADDR_W];
  assign bitMask   = BYTE_W'(1) << errBit;
  assign bufWrData = bufRdData ^ bitMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= ST_OK;
    end else if (strobe.latchResult) begin
      unique case (cls)
        CLS_OK:       status <= ST_OK;
        CLS_FIX_DATA: status <= ST_FIXED;
        CLS_FIX_ECC:  status <= ST_FIXED;
        default:      status <= ST_BAD;
      endcase
    end
  end

  // R1: a zero syndrome ends as a clean status
  a_r1_zero_clean: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchResult && syndReg == '0) |=> status == ST_OK);

  // R5: a lone flipped check bit reports corrected
  a_r5_single_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchResult && !blankReg && $countones(syndReg) == 1) |=> status == ST_FIXED);

  // R6: several bits without the pair pattern report uncorrectable
  a_r6_multi_bad: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchResult && !blankReg && !allPairs && $countones(syndReg) > 1)
      |=> status == ST_BAD);

endmodule

// File: rtl/ecc_fix_control.sv
module ecc_fix_control
  import ecc_fix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStrobe,
  input  eccClass_e  cls,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {
    S_IDLE, S_CLASS, S_READ, S_WRITE, S_DONE
  } ctlState_e;

  ctlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (startStrobe) stateNext = S_CLASS;
      S_CLASS: stateNext = (cls == CLS_FIX_DATA) ? S_READ : S_DONE;
      S_READ:  stateNext = S_WRITE;
      S_WRITE: stateNext = S_DONE;
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe             = '0;
    strobe.capture     = (state == S_IDLE) && startStrobe;
    strobe.latchResult = (state == S_CLASS);
    strobe.rdEn        = (state == S_READ);
    strobe.wrEn        = (state == S_WRITE);
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  // R4: every write-back is preceded by the read of the same byte
  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> $past(strobe.rdEn));

  // R7: done lasts a single cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: no buffer traffic while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(strobe.rdEn || strobe.wrEn));

endmodule

// File: rtl/ecc_fix_top.sv
module ecc_fix_top
  import ecc_fix_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int ECC_BYTES = 3,
  localparam int SYN_W    = BYTE_W * ECC_BYTES,
  localparam int LOC_W    = SYN_W / 2,
  localparam int BIT_W    = $clog2(BYTE_W),
  localparam int ADDR_W   = LOC_W - BIT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic              ignoreBlank,
  input  logic [SYN_W-1:0]  storedEcc,
  input  logic [SYN_W-1:0]  calcEcc,
  input  logic [BYTE_W-1:0] bufRdData,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              bufRdEn,
  output logic              bufWrEn,
  output logic [BYTE_W-1:0] bufWrData,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] errByte,
  output logic [BIT_W-1:0]  errBit
);

  ctlStrobe_t strobe;
  eccClass_e  cls;

  ecc_fix_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .startStrobe (startStrobe),
    .cls         (cls),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done)
  );

  ecc_fix_datapath #(
    .BYTE_W    (BYTE_W),
    .ECC_BYTES (ECC_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .storedEcc   (storedEcc),
    .calcEcc     (calcEcc),
    .ignoreBlank (ignoreBlank),
    .bufRdData   (bufRdData),
    .cls         (cls),
    .errByte     (errByte),
    .errBit      (errBit),
    .bufWrData   (bufWrData),
    .status      (status)
  );

  assign bufAddr = errByte;
  assign bufRdEn = strobe.rdEn;
  assign bufWrEn = strobe.wrEn;

  // R4: a write only happens once the result has been latched as corrected
  a_r4_write_is_fixed: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> status == ST_FIXED);

  // R8: the error location cannot move while an operation is in flight
  a_r8_busy_holds_loc: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(errByte) && $stable(errBit)));

endmodule

// File: tb/ecc_fix_top_tb_top.sv
module ecc_fix_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStrobe = 1'b0;
  logic        ignoreBlank = 1'b0;
  logic [23:0] storedEcc = '0;
  logic [23:0] calcEcc = '0;
  logic [7:0]  bufRdData;
  logic [8:0]  bufAddr;
  logic        bufRdEn, bufWrEn, busy, done;
  logic [7:0]  bufWrData;
  logic [1:0]  status;
  logic [8:0]  errByte;
  logic [2:0]  errBit;

  int testsRun = 0;
  int testsFailed = 0;
  int wrCount = 0;
  logic [8:0] lastWrAddr = '0;
  logic [7:0] lastWrData = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  ecc_fix_top dut_i (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .ignoreBlank(ignoreBlank),
    .storedEcc(storedEcc), .calcEcc(calcEcc), .bufRdData(bufRdData),
    .bufAddr(bufAddr), .bufRdEn(bufRdEn), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .busy(busy), .done(done), .status(status), .errByte(errByte), .errBit(errBit)
  );

  function automatic logic [7:0] romVal(input logic [8:0] a);
    return 8'((a * 37) + (a >> 3) + 9'h05A);
  endfunction

  always_ff @(posedge clk) begin
    if (bufRdEn) bufRdData <= romVal(bufAddr);
    if (bufWrEn) begin
      wrCount    <= wrCount + 1;
      lastWrAddr <= bufAddr;
      lastWrData <= bufWrData;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 clean, 1 data fix, 2 check-byte fix, 3 bad
  function automatic int expClass(input logic [23:0] st, input logic [23:0] ca, input bit ign);
    logic [23:0] s;
    bit pairs;
    s = st ^ ca;
    if (s == 0) return 0;
    if (ign && st == 24'hFFFFFF) return 0;
    pairs = 1;
    for (int p = 0; p < 12; p++) if (s[2*p] == s[2*p+1]) pairs = 0;
    if (pairs) return 1;
    if ($countones(s) == 1) return 2;
    return 3;
  endfunction

  function automatic logic [23:0] buildSynd(input int loc);
    logic [23:0] s;
    s = '0;
    for (int i = 0; i < 12; i++) s[2*i + (((loc >> i) & 1) != 0 ? 1 : 0)] = 1'b1;
    return s;
  endfunction

  task automatic doOp(input logic [23:0] st, input logic [23:0] ca, input bit ign,
                      input string req);
    int cl, lat, w0, locv, eByte, eBit;
    logic [1:0] eStat;
    logic [23:0] s;
    cl = expClass(st, ca, ign);
    s = st ^ ca;
    locv = 0;
    for (int i = 0; i < 12; i++) if (s[2*i+1]) locv |= (1 << i);
    eByte = locv & 9'h1FF;
    eBit  = (locv >> 9) & 7;
    eStat = (cl == 0) ? 2'b00 : (cl == 3) ? 2'b11 : 2'b01;
    w0 = wrCount;
    @(negedge clk);
    storedEcc = st; calcEcc = ca; ignoreBlank = ign; startStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startStrobe = 1'b0;
    lat = 1;
    while (!done && lat < 12) begin @(negedge clk); lat++; end
    chk(status == eStat, {req, " status"}, status, eStat);
    chk(lat == ((cl == 1) ? 4 : 2), "R7 latency", lat, (cl == 1) ? 4 : 2);
    chk(wrCount - w0 == ((cl == 1) ? 1 : 0), {req, " write count"}, wrCount - w0, (cl == 1) ? 1 : 0);
    if (cl == 1) begin
      chk(errByte == eByte && errBit == eBit, "R3 location", {errBit, errByte}, (eBit << 9) | eByte);
      chk(lastWrAddr == eByte, "R4 write address", lastWrAddr, eByte);
      chk(lastWrData == (romVal(9'(eByte)) ^ (8'd1 << eBit)), "R4 write data",
          lastWrData, romVal(9'(eByte)) ^ (8'd1 << eBit));
    end
    @(negedge clk);
    chk(!done && !busy, "R7 done pulse", {done, busy}, 0);
  endtask

  initial begin
    logic [23:0] c;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !bufRdEn && !bufWrEn && status == 2'b00, "R9 reset",
        {done, busy, bufRdEn, bufWrEn, status}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !bufRdEn && !bufWrEn, "R9 after reset", {done, busy, bufRdEn, bufWrEn}, 0);

    // R1 zero syndrome
    doOp(24'h000000, 24'h000000, 1'b0, "R1");
    doOp(24'h123456, 24'h123456, 1'b0, "R1");
    doOp(24'hFFFFFF, 24'hFFFFFF, 1'b1, "R1");

    // R2 blank stored code
    for (int k = 0; k < 8; k++) begin
      c = 24'($urandom());
      doOp(24'hFFFFFF, c, 1'b1, "R2 ignored");
      doOp(24'hFFFFFF, c, 1'b0, "R2 classified");
    end
    doOp(24'hFFFFFF, 24'hFFFFFF ^ buildSynd(12'h0A5), 1'b0, "R2 classified fix");

    // R5 every single-bit syndrome
    for (int b = 0; b < 24; b++) begin
      c = 24'($urandom());
      doOp(c ^ (24'd1 << b), c, 1'b0, "R5");
    end

    // R3/R4 every byte and bit location
    for (int loc = 0; loc < 4096; loc++) begin
      c = 24'($urandom());
      doOp(c ^ buildSynd(loc), c, 1'b0, "R3");
    end

    // R6 every two-bit syndrome plus random patterns
    for (int i = 0; i < 24; i++)
      for (int j = i + 1; j < 24; j++)
        doOp((24'd1 << i) | (24'd1 << j), 24'h000000, 1'b0, "R6");
    for (int k = 0; k < 200; k++) doOp(24'($urandom()), 24'($urandom()), 1'b0, "R6 random");

    // R8 start held high through a correcting operation with other inputs
    begin
      int w0, lat;
      w0 = wrCount;
      @(negedge clk);
      storedEcc = buildSynd(12'h5C3); calcEcc = 24'h0; ignoreBlank = 1'b0; startStrobe = 1'b1;
      @(posedge clk);
      @(negedge clk);
      storedEcc = buildSynd(12'h21E); calcEcc = 24'h0;
      lat = 1;
      while (!done && lat < 12) begin @(negedge clk); lat++; end
      startStrobe = 1'b0;
      chk(status == 2'b01 && lat == 4, "R8 status", {status, 4'(lat)}, 8'h14);
      chk(errByte == 9'h1C3 && errBit == 3'd2, "R8 location", {errBit, errByte}, {3'd2, 9'h1C3});
      chk(wrCount - w0 == 1 && lastWrAddr == 9'h1C3, "R8 one write", wrCount - w0, 1);
      chk(lastWrData == (romVal(9'h1C3) ^ 8'h04), "R8 write data", lastWrData, romVal(9'h1C3) ^ 8'h04);
      @(negedge clk);
      chk(!busy && !done, "R8 no restart", {busy, done}, 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R7 watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule